// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupts

The block is one general-purpose I/O port with up to 32 pins behind a small memory-mapped register interface. Software writes an output data register and a direction register; the block drives each pad's output value and output enable from them. The external pins pass through a two-flop synchroniser. The synchronised levels can be read back through a read-only input register.

Each pin has its own interrupt logic. An enable bit, a type bit and a polarity bit give four triggers: rising edge, falling edge, high level and low level. Both-edge triggering is not available. An edge event sets a pending latch that stays set until software writes a one to that pin's bit of the clear register. A level interrupt has no latch and tracks the pin. Per-pin status is readable, and the OR of all status bits drives a single interrupt request line.

Register offsets (byte addresses): 0x00 output data, 0x04 direction, 0x08 reserved, 0x30 interrupt enable, 0x34 interrupt type, 0x38 interrupt polarity, 0x3C interrupt status (read-only), 0x40 interrupt clear (write-only, reads 0), 0x44 pin input (read-only). Any other offset reads 0. A write takes effect at the clock edge where req_i and we_i are both high. Read data is combinational from addr_i.

Top module: `gpio_port`

## Requirements
- R1: After reset, gpio_out_o, gpio_oe_o and irq_o are 0, and every register reads 0.
- R2: A write to 0x00 sets gpio_out_o from the next cycle, and 0x00 reads back the last written value, so a read-modify-write of one bit leaves the others unchanged.
- R3: A write to 0x04 sets gpio_oe_o from the next cycle. Bit value 1 makes that pin an output and 0 makes it an input. The value reads back at 0x04.
- R4: Offset 0x44 returns gpio_in_i as it was two clock edges earlier. After a change on a pin, one clock edge is not enough for the new level to be read.
- R5: With enable=1, type=1 and polarity=1, a 0-to-1 change of the synchronised pin sets its status bit at 0x3C. The bit stays set after the pin returns to 0.
- R6: With enable=1, type=1 and polarity=0, a 1-to-0 change sets the status bit, and a 0-to-1 change does not.
- R7: With enable=1, type=0 and polarity=1, the status bit equals the synchronised pin level and is not latched.
- R8: With enable=1, type=0 and polarity=0, the status bit equals the inverted synchronised pin level.
- R9: A pin whose enable bit is 0 shows status 0. An edge that occurs while the pin is disabled does not show up after the pin is enabled.
- R10: Writing 1 to a bit at 0x40 clears that pin's pending edge latch. Writing 0 leaves it set.
- R11: irq_o is 1 exactly when at least one status bit is 1.
- R12: Writes to 0x08, 0x3C and 0x44 change nothing. 0x08 and 0x40 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| gpio_in_i | input | 32 | External pin levels (asynchronous) |
| gpio_out_o | output | 32 | Pad output values |
| gpio_oe_o | output | 32 | Pad output enables, 1 = drive |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The properties assume that register accesses are single-cycle strobes on aligned offsets. The clear property only constrains bits that have no new edge in the same cycle, because a new edge takes priority over a clear. The pins are treated as asynchronous, so the bench changes gpio_in_i only on falling clock edges and holds each level for at least three cycles before it samples status. This lets every edge pass the synchroniser and the latch before the check. Each interrupt test sets type and polarity before enable, and sets the pin to its idle level first, so that no trigger appears while the configuration is being changed.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_DATA = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_RSV  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_EN   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_TYPE = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_POL  = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_IN   = 8'h44;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      status_i,
  input  logic [W-1:0]      pins_i,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      type_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      clr_o
);
  logic wr;
  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      en_q   <= '0;
      type_q <= '0;
      pol_q  <= '0;
    end else if (wr) begin
      case (addr_i)
        OFS_DATA: data_q <= wdata_i;
        OFS_DIR:  dir_q  <= wdata_i;
        OFS_EN:   en_q   <= wdata_i;
        OFS_TYPE: type_q <= wdata_i;
        OFS_POL:  pol_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o = (wr && addr_i == OFS_CLR) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      OFS_DATA: rdata_o = data_q;
      OFS_DIR:  rdata_o = dir_q;
      OFS_EN:   rdata_o = en_q;
      OFS_TYPE: rdata_o = type_q;
      OFS_POL:  rdata_o = pol_q;
      OFS_STAT: rdata_o = status_i;
      OFS_IN:   rdata_o = pins_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] type_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] edge_hit_o,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, lvl, pend_q;
    assign rise = sync_i[i] & ~prev_i[i];
    assign fall = ~sync_i[i] & prev_i[i];
    assign lvl  = pol_i[i] ? sync_i[i] : ~sync_i[i];
    assign edge_hit_o[i] = en_i[i] & type_i[i] & (pol_i[i] ? rise : fall);

    // a new edge wins over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= edge_hit_o[i] | (pend_q & ~clr_i[i]);
    end

    assign pend_o[i]   = pend_q;
    assign status_o[i] = en_i[i] & (type_i[i] ? pend_q : lvl);
  end

  assign irq_o = |status_o;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] gpio_in_i,
  output logic [NUM_PINS-1:0] gpio_out_o,
  output logic [NUM_PINS-1:0] gpio_oe_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] sync, prev, status, en_q, type_q, pol_q, clr, edge_hit, pend_q;

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i, .rst_ni, .async_i(gpio_in_i), .sync_o(sync), .prev_o(prev)
  );

  gpio_regs #(.W(NUM_PINS)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .status_i(status), .pins_i(sync),
    .data_q(gpio_out_o), .dir_q(gpio_oe_o),
    .en_q, .type_q, .pol_q, .clr_o(clr)
  );

  gpio_irq #(.W(NUM_PINS)) u_irq (
    .clk_i, .rst_ni, .en_i(en_q), .type_i(type_q), .pol_i(pol_q),
    .sync_i(sync), .prev_i(prev), .clr_i(clr),
    .edge_hit_o(edge_hit), .pend_o(pend_q), .status_o(status), .irq_o
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] gpio_out_o,
  input logic [NUM_PINS-1:0] gpio_oe_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] pend_q,
  input logic [NUM_PINS-1:0] edge_hit
);
  a_r2_out_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_DATA) |=> gpio_out_o == $past(wdata_i));

  a_r3_oe_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_DIR) |=> gpio_oe_o == $past(wdata_i));

  a_r5_pend_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_hit == '0) |=> (pend_q & ~$past(pend_q)) == '0);

  a_r9_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en_q != '0);

  a_r10_clear_drops_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_CLR && (edge_hit & wdata_i) == '0)
      |=> (pend_q & $past(wdata_i)) == '0);
endmodule

bind gpio_port gpio_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
  .gpio_out_o, .gpio_oe_o, .irq_o, .en_q, .pend_q, .edge_hit
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  logic        clk = 0, rst_ni = 0, req = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, pins = 0, gout, goe;
  logic        irq;
  int          total = 0, bad = 0;

  gpio_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .gpio_in_i(pins),
    .gpio_out_o(gout), .gpio_oe_o(goe), .irq_o(irq)
  );

  always #2 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; req = 1; we = 0; #1; d = rdata; req = 0;
  endtask

  task automatic chk_rd(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v); check(tag, v, exp);
  endtask

  task automatic set_pins(logic [31:0] v);
    @(negedge clk); pins = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 out", gout, 0); check("R1 oe", goe, 0); check("R1 irq", {31'b0, irq}, 0);
    chk_rd("R1 data", 8'h00, 0); chk_rd("R1 dir", 8'h04, 0); chk_rd("R1 en", 8'h30, 0);
    chk_rd("R1 type", 8'h34, 0); chk_rd("R1 pol", 8'h38, 0); chk_rd("R1 stat", 8'h3C, 0);
    chk_rd("R1 in", 8'h44, 0);
  endtask

  task automatic t_data;
    logic [31:0] v;
    wr(8'h00, 32'hA5A5_0F0F);
    check("R2 out", gout, 32'hA5A5_0F0F); chk_rd("R2 readback", 8'h00, 32'hA5A5_0F0F);
    rd(8'h00, v); wr(8'h00, v | 32'h10);
    check("R2 rmw", gout, 32'hA5A5_0F1F);
  endtask

  task automatic t_dir;
    wr(8'h04, 32'hFFFF_0000);
    check("R3 oe", goe, 32'hFFFF_0000); chk_rd("R3 readback", 8'h04, 32'hFFFF_0000);
    check("R3 out kept", gout, 32'hA5A5_0F1F);
  endtask

  task automatic t_input;
    @(negedge clk); pins = 32'h1234_5678;
    @(negedge clk); chk_rd("R4 one edge", 8'h44, 0);
    @(negedge clk); chk_rd("R4 two edges", 8'h44, 32'h1234_5678);
    set_pins(0);
    chk_rd("R4 back to zero", 8'h44, 0);
  endtask

  task automatic t_rise;
    wr(8'h34, 1); wr(8'h38, 1); wr(8'h30, 1);
    set_pins(32'h1);
    chk_rd("R5 set", 8'h3C, 1); check("R11 irq on", {31'b0, irq}, 1);
    set_pins(0);
    chk_rd("R5 latched", 8'h3C, 1);
    wr(8'h40, 0); chk_rd("R10 zero no effect", 8'h3C, 1);
    wr(8'h40, 1); chk_rd("R10 cleared", 8'h3C, 0);
    check("R11 irq off", {31'b0, irq}, 0);
    wr(8'h30, 0);
  endtask

  task automatic t_fall;
    wr(8'h34, 2); wr(8'h38, 0); wr(8'h30, 2);
    set_pins(32'h2); chk_rd("R6 rise ignored", 8'h3C, 0);
    set_pins(0);     chk_rd("R6 fall set", 8'h3C, 2);
    wr(8'h40, 2);    chk_rd("R10 fall cleared", 8'h3C, 0);
    wr(8'h30, 0);
  endtask

  task automatic t_high;
    wr(8'h34, 0); wr(8'h38, 4); wr(8'h30, 4);
    chk_rd("R7 idle", 8'h3C, 0);
    set_pins(32'h4); chk_rd("R7 high", 8'h3C, 4); check("R11 level irq", {31'b0, irq}, 1);
    set_pins(0);     chk_rd("R7 not latched", 8'h3C, 0); check("R11 level irq off", {31'b0, irq}, 0);
    wr(8'h30, 0);
  endtask

  task automatic t_low;
    set_pins(32'h8);
    wr(8'h34, 0); wr(8'h38, 0); wr(8'h30, 8);
    chk_rd("R8 high pin", 8'h3C, 0);
    set_pins(0);     chk_rd("R8 low pin", 8'h3C, 8);
    set_pins(32'h8); chk_rd("R8 not latched", 8'h3C, 0);
    wr(8'h30, 0);
    set_pins(0);     chk_rd("R9 low masked", 8'h3C, 0); check("R9 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_disable;
    wr(8'h34, 32'h10); wr(8'h38, 32'h10);
    set_pins(32'h10); chk_rd("R9 disabled edge", 8'h3C, 0); check("R9 no irq", {31'b0, irq}, 0);
    wr(8'h30, 32'h10); chk_rd("R9 not kept", 8'h3C, 0);
    wr(8'h30, 0); set_pins(0);
  endtask

  task automatic t_or;
    wr(8'h34, 32'h21); wr(8'h38, 32'h21); wr(8'h30, 32'h21);
    set_pins(32'h21); set_pins(0);
    chk_rd("R11 two pending", 8'h3C, 32'h21);
    wr(8'h40, 1); chk_rd("R10 one left", 8'h3C, 32'h20);
    check("R11 irq one left", {31'b0, irq}, 1);
    wr(8'h40, 32'h20); check("R11 irq none", {31'b0, irq}, 0);
    wr(8'h30, 0);
  endtask

  task automatic t_readonly;
    set_pins(32'h0000_0300);
    wr(8'h3C, 32'hFFFF_FFFF); wr(8'h44, 32'hFFFF_FFFF); wr(8'h08, 32'hFFFF_FFFF);
    chk_rd("R12 stat", 8'h3C, 0); chk_rd("R12 in", 8'h44, 32'h0000_0300);
    chk_rd("R12 rsv", 8'h08, 0); chk_rd("R12 clr reads 0", 8'h40, 0);
    chk_rd("R12 en kept", 8'h30, 0);
    check("R12 out kept", gout, 32'hA5A5_0F1F); check("R12 oe kept", goe, 32'hFFFF_0000);
    check("R12 irq", {31'b0, irq}, 0);
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_data();
    t_dir();
    t_input();
    t_rise();
    t_fall();
    t_high();
    t_low();
    t_disable();
    t_or();
    t_readonly();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule